// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is a 4096-word scratchpad spread over 16 single-ported banks of 32-bit words. A group of 16 lanes hands it one request at a time: each lane carries a valid bit, a word address, a write enable and write data. The block latches the whole group, works out which banks are contended, and services the group over the smallest number of cycles that the bank ports allow. Lanes that name the very same address are served together and share one bank access, so a common read is broadcast to all of them.

A request is taken on a cycle where `req_valid` is high and `busy` is low. From the next cycle `busy` stays high for one cycle per serialization step. When the last lane is served, `busy` drops and `done` pulses for one cycle. The per-lane read data is then held until the next request is taken.

Top module: `smem_conflict_serializer`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every lane of `rd_data` is 0.
- R2: A request is taken only when `req_valid` is 1 and `busy` is 0; a `req_valid` pulse while `busy` is 1 has no effect on the data returned, on the cycle count or on the stored contents.
- R3: The bank of a word address is its low 4 bits (address modulo 16) and the row inside the bank is the upper 8 bits (address divided by 16); every one of the 4096 addresses stores and returns its own word.
- R4: When all valid lanes hit different banks, `busy` is high for exactly 1 cycle.
- R5: Valid lanes that name the identical address are served in the same cycle and all receive the same read data, adding no extra cycle.
- R6: `busy` stays high for exactly as many cycles as the largest count of distinct addresses that valid lanes place in any one bank (stride 2 takes 2 cycles, stride 8 takes 8, stride 16 takes 16), and at least 1 cycle.
- R7: When several lanes of one request write the same address, the data of the highest-numbered writing lane is the one stored.
- R8: Every valid lane, writer or reader, returns the word its address held before the request; writes of the request take effect for later requests.
- R9: `done` is a one-cycle pulse in the cycle right after the last `busy` cycle, and `rd_data` stays unchanged from then until the next request is taken.
- R10: Lanes with the valid bit at 0 write nothing and return 0; a request with no valid lane still takes 1 `busy` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Offers a request; taken when `busy` is 0 |
| lane_valid | input | 16 | Per-lane valid bit, bit n for lane n |
| lane_addr | input | 192 | Per-lane 12-bit word address, lane n at bits [12n+11:12n] |
| lane_we | input | 16 | Per-lane write enable, bit n for lane n |
| lane_wdata | input | 512 | Per-lane 32-bit write data, lane n at bits [32n+31:32n] |
| busy | output | 1 | High while the taken request is being serialized |
| done | output | 1 | One-cycle pulse after the last lane is served |
| rd_data | output | 512 | Per-lane 32-bit read data, lane n at bits [32n+31:32n] |

## Verification
Every cycle the assertions check the handshake: a taken request raises `busy`, nothing joins the pending set while `busy` is high, each `busy` cycle retires at least one lane, `done` pulses only when `busy` falls, and `rd_data` stays put while idle. Whether the cycle count equals the worst per-bank count of distinct addresses, whether a broadcast or a same-address write resolves to the right word, and whether each address reaches its own bank row can only be shown by the bench, which drives stride sweeps, broadcast, write-collision and pseudo-random patterns against an arithmetic model of the memory.

// File: rtl/smem_pkg.sv
// Package smem_pkg
// Shared sizing constants for the banked scratchpad.
// Assumes word addressing and a power-of-two bank count and capacity.
package smem_pkg;
    localparam int SMEM_LANES = 16;
    localparam int SMEM_BANKS = 16;
    localparam int SMEM_WORDS = 4096;
    localparam int SMEM_DW    = 32;
endpackage

// File: rtl/smem_bank.sv
// Module smem_bank
// One single-ported bank: asynchronous read of the addressed row,
// write on the rising edge. Contents are not reset.
// Assumes at most one row is addressed per cycle.
module smem_bank #(
    parameter int DW    = 32,
    parameter int DEPTH = 256,
    localparam int RW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [RW-1:0] row,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store [DEPTH];

    // Purpose: commit the granted write into the addressed row
    always_ff @(posedge clk) begin
        if (we) begin
            store[row] <= wdata;
        end
    end

    assign rdata = store[row];
endmodule

// File: rtl/smem_bank_arbiter.sv
// Module smem_bank_arbiter
// Grant logic for one bank: picks the lowest pending lane that maps to
// this bank, then grants every pending lane with that exact address.
// Among granted writers the highest-numbered lane supplies the data.
// Assumes the bank index is the low address bits.
module smem_bank_arbiter #(
    parameter int LANES   = 16,
    parameter int BANKS   = 16,
    parameter int AW      = 12,
    parameter int DW      = 32,
    parameter int BANK_ID = 0,
    localparam int BW     = $clog2(BANKS),
    localparam int RW     = AW - BW
) (
    input  logic [LANES-1:0]    pend,
    input  logic [LANES*AW-1:0] addr_flat,
    input  logic [LANES-1:0]    we_mask,
    input  logic [LANES*DW-1:0] wdata_flat,
    output logic [LANES-1:0]    grant,
    output logic [RW-1:0]       row,
    output logic                bank_we,
    output logic [DW-1:0]       bank_wdata
);
    logic          found;
    logic [AW-1:0] lead_addr;

    // Purpose: find the lead lane of this bank and grant its address group
    always_comb begin
        found      = 1'b0;
        lead_addr  = '0;
        grant      = '0;
        bank_we    = 1'b0;
        bank_wdata = '0;
        for (int l = 0; l < LANES; l++) begin
            if (!found && pend[l] && addr_flat[l*AW +: BW] == BW'(BANK_ID)) begin
                found     = 1'b1;
                lead_addr = addr_flat[l*AW +: AW];
            end
        end
        for (int l = 0; l < LANES; l++) begin
            if (found && pend[l] && addr_flat[l*AW +: AW] == lead_addr) begin
                grant[l] = 1'b1;
                if (we_mask[l]) begin
                    bank_we    = 1'b1;
                    bank_wdata = wdata_flat[l*DW +: DW];
                end
            end
        end
    end

    assign row = lead_addr[AW-1:BW];
endmodule

// File: rtl/smem_conflict_serializer.sv
// Module smem_conflict_serializer
// Banked scratchpad serving one group of lanes per request. Latches the
// group, grants one address per bank per cycle, broadcasts shared reads,
// raises busy while serializing and pulses done when all lanes are served.
// Assumes requests are offered only from one lane group at a time.
module smem_conflict_serializer
    import smem_pkg::*;
#(
    parameter int LANES  = SMEM_LANES,
    parameter int BANKS  = SMEM_BANKS,
    parameter int WORDS  = SMEM_WORDS,
    parameter int DW     = SMEM_DW,
    localparam int AW    = $clog2(WORDS),
    localparam int BW    = $clog2(BANKS),
    localparam int DEPTH = WORDS / BANKS,
    localparam int RW    = AW - BW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [LANES-1:0]    lane_valid,
    input  logic [LANES*AW-1:0] lane_addr,
    input  logic [LANES-1:0]    lane_we,
    input  logic [LANES*DW-1:0] lane_wdata,
    output logic                busy,
    output logic                done,
    output logic [LANES*DW-1:0] rd_data
);
    logic [LANES-1:0]    pend;
    logic [LANES*AW-1:0] addr_q;
    logic [LANES-1:0]    we_q;
    logic [LANES*DW-1:0] wdata_q;
    logic [LANES*DW-1:0] rd_q;

    logic [LANES-1:0] grant_by_bank [BANKS];
    logic [DW-1:0]    bank_rd       [BANKS];
    logic [LANES-1:0] grant_all;
    logic [LANES-1:0] pend_next;
    logic [DW-1:0]    lane_rd       [LANES];
    logic             accept;

    assign accept = req_valid && !busy;

    // One arbiter and one storage bank per bank index
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [RW-1:0] row;
        logic          arb_we;
        logic [DW-1:0] arb_wd;

        smem_bank_arbiter #(
            .LANES(LANES), .BANKS(BANKS), .AW(AW), .DW(DW), .BANK_ID(b)
        ) u_arb (
            .pend(pend), .addr_flat(addr_q), .we_mask(we_q),
            .wdata_flat(wdata_q), .grant(grant_by_bank[b]), .row(row),
            .bank_we(arb_we), .bank_wdata(arb_wd)
        );

        smem_bank #(.DW(DW), .DEPTH(DEPTH)) u_mem (
            .clk(clk), .we(busy && arb_we), .row(row),
            .wdata(arb_wd), .rdata(bank_rd[b])
        );
    end

    // Purpose: merge the per-bank grants into one lane mask
    always_comb begin
        grant_all = '0;
        for (int b = 0; b < BANKS; b++) begin
            grant_all = grant_all | grant_by_bank[b];
        end
    end

    assign pend_next = pend & ~grant_all;

    // Purpose: route each lane to the read port of its own bank
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            lane_rd[l] = bank_rd[addr_q[l*AW +: BW]];
        end
    end

    // Purpose: take requests, retire granted lanes and capture their data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            pend    <= '0;
            addr_q  <= '0;
            we_q    <= '0;
            wdata_q <= '0;
            rd_q    <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy    <= 1'b1;
                pend    <= lane_valid;
                addr_q  <= lane_addr;
                we_q    <= lane_we;
                wdata_q <= lane_wdata;
                rd_q    <= '0;
            end else if (busy) begin
                pend <= pend_next;
                for (int l = 0; l < LANES; l++) begin
                    if (grant_all[l]) begin
                        rd_q[l*DW +: DW] <= lane_rd[l];
                    end
                end
                if (pend_next == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign rd_data = rd_q;

    // R2: a taken request starts serialization on the next cycle
    assert_accept_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R2: no lane joins the pending set while a request is in flight
    assert_no_join_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((pend & ~$past(pend)) == '0));

    // R6: every serialization cycle retires at least one pending lane
    assert_progress_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (pend != '0)) |=> ($countones(pend) < $countones($past(pend))));

    // R9: done only follows a busy cycle
    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // R9: the end of busy is always marked by done
    assert_busy_end_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R9: read data holds while idle and no request is taken
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (busy || $stable(rd_data)));
endmodule

// File: tb/smem_conflict_serializer_tb.sv
module smem_conflict_serializer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 16;
    localparam int AWB = 12;
    localparam int DWB = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [NL-1:0] lane_valid = '0;
    logic [NL*AWB-1:0] lane_addr = '0;
    logic [NL-1:0] lane_we = '0;
    logic [NL*DWB-1:0] lane_wdata = '0;
    logic busy, done;
    logic [NL*DWB-1:0] rd_data;

    smem_conflict_serializer u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .lane_valid(lane_valid), .lane_addr(lane_addr), .lane_we(lane_we),
        .lane_wdata(lane_wdata), .busy(busy), .done(done), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_total = 0;
    logic [31:0] model [4096];
    logic [11:0] t_addr [NL];
    logic [NL-1:0] t_we;
    logic [31:0] t_wd [NL];
    logic [31:0] seed = 32'h1234_5678;

    always @(posedge clk) begin
        cyc_total <= cyc_total + 1;
        if (cyc_total > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Issues one request, counts busy cycles and compares against the model.
    task automatic run_req(input logic [NL-1:0] vm, input string req, input bit inject);
        logic [31:0] exp_rd [NL];
        int exp_cyc, cyc, wd;
        logic [NL*DWB-1:0] held;
        // expected read data: value before the request (R8), 0 when invalid (R10)
        for (int l = 0; l < NL; l++) exp_rd[l] = vm[l] ? model[t_addr[l]] : 32'h0;
        // expected cycles: worst count of distinct addresses in a bank (R6)
        exp_cyc = 1;
        for (int b = 0; b < 16; b++) begin
            int cnt = 0;
            for (int l = 0; l < NL; l++) begin
                if (vm[l] && t_addr[l][3:0] == 4'(b)) begin
                    bit seen = 1'b0;
                    for (int k = 0; k < l; k++)
                        if (vm[k] && t_addr[k] == t_addr[l]) seen = 1'b1;
                    if (!seen) cnt++;
                end
            end
            if (cnt > exp_cyc) exp_cyc = cnt;
        end
        // writes land in lane order so the highest lane wins (R7)
        for (int l = 0; l < NL; l++)
            if (vm[l] && t_we[l]) model[t_addr[l]] = t_wd[l];
        @(negedge clk);
        lane_valid = vm;
        lane_we = t_we;
        for (int l = 0; l < NL; l++) begin
            lane_addr[l*AWB +: AWB] = t_addr[l];
            lane_wdata[l*DWB +: DWB] = t_wd[l];
        end
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        wd = 0;
        while (busy && wd < 40) begin
            cyc++;
            wd++;
            if (inject && cyc == 1) begin
                req_valid = 1'b1;
                lane_valid = '1;
                lane_we = '1;
                for (int l = 0; l < NL; l++) begin
                    lane_addr[l*AWB +: AWB] = 12'(l);
                    lane_wdata[l*DWB +: DWB] = 32'hDEAD_0000 + l;
                end
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(done == 1'b1, {req, " R9 done pulse"}, {31'b0, done}, 32'h1);
        check(cyc == exp_cyc, {req, " R6 busy cycles"}, cyc, exp_cyc);
        for (int l = 0; l < NL; l++)
            check(rd_data[l*DWB +: DWB] === exp_rd[l], {req, " read data"},
                  rd_data[l*DWB +: DWB], exp_rd[l]);
        held = rd_data;
        @(negedge clk);
        check(done == 1'b0, {req, " R9 done one cycle"}, {31'b0, done}, 32'h0);
        check(rd_data === held, {req, " R9 data held"}, rd_data[31:0], held[31:0]);
    endtask

    task automatic set_reads();
        t_we = '0;
        for (int l = 0; l < NL; l++) t_wd[l] = 32'h0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1 busy", {31'b0, busy}, 32'h0);
        check(done == 1'b0, "R1 done", {31'b0, done}, 32'h0);
        check(rd_data == '0, "R1 rd_data", rd_data[31:0], 32'h0);
        rst_n = 1'b1;

        // R3 R4: fill every address through conflict-free linear writes
        for (int base = 0; base < 4096; base += 16) begin
            for (int l = 0; l < NL; l++) begin
                t_addr[l] = 12'(base + l);
                t_wd[l] = 32'hA500_0000 ^ (32'(base + l) * 32'h9E37);
            end
            t_we = '1;
            run_req('1, "R4 fill", 1'b0);
        end
        // R3: read back every address, bank = addr mod 16, row = addr / 16
        for (int base = 0; base < 4096; base += 16) begin
            set_reads();
            for (int l = 0; l < NL; l++) t_addr[l] = 12'((base + 15 - l) ^ 12'h0);
            run_req('1, "R3 readback", 1'b0);
        end

        // R6: stride sweep, reads then writes
        for (int s = 1; s <= 16; s++) begin
            for (int bi = 0; bi < 3; bi++) begin
                int bases [3] = '{0, 5, 1000};
                set_reads();
                for (int l = 0; l < NL; l++) t_addr[l] = 12'(bases[bi] + l * s);
                run_req('1, "R6 stride read", 1'b0);
                t_we = '1;
                for (int l = 0; l < NL; l++) begin
                    seed = nxt(seed);
                    t_wd[l] = seed;
                end
                run_req('1, "R6 stride write", 1'b0);
            end
        end

        // R5: full broadcast and partial broadcast
        set_reads();
        for (int l = 0; l < NL; l++) t_addr[l] = 12'd77;
        run_req('1, "R5 broadcast", 1'b0);
        for (int l = 0; l < NL; l++) t_addr[l] = (l < 8) ? 12'd200 : 12'(l);
        run_req('1, "R5 half broadcast", 1'b0);

        // R7: all lanes write one address; then two lanes collide
        t_we = '1;
        for (int l = 0; l < NL; l++) begin
            t_addr[l] = 12'd300;
            t_wd[l] = 32'hC0DE_0000 + l;
        end
        run_req('1, "R7 same write", 1'b0);
        set_reads();
        for (int l = 0; l < NL; l++) t_addr[l] = 12'd300;
        run_req('1, "R7 readback", 1'b0);
        t_we = 16'h0208;
        for (int l = 0; l < NL; l++) begin
            t_addr[l] = (l == 3 || l == 9) ? 12'd321 : 12'(2000 + l);
            t_wd[l] = 32'hB0B0_0000 + l;
        end
        run_req('1, "R7 two writers", 1'b0);
        set_reads();
        run_req('1, "R7 two writers readback", 1'b0);

        // R8: readers share a cycle with a writer and see the old word
        t_we = 16'h0100;
        for (int l = 0; l < NL; l++) begin
            t_addr[l] = (l <= 8) ? 12'd400 : 12'(416 + l * 16);
            t_wd[l] = 32'h5555_AAAA;
        end
        run_req('1, "R8 read before write", 1'b0);
        set_reads();
        run_req('1, "R8 later read", 1'b0);

        // R10: empty request, and invalid lanes that would write
        set_reads();
        run_req('0, "R10 empty", 1'b0);
        t_we = '1;
        for (int l = 0; l < NL; l++) begin
            t_addr[l] = (l < 4) ? 12'(600 + l) : 12'd500;
            t_wd[l] = 32'hEEEE_0000 + l;
        end
        run_req(16'h000F, "R10 invalid lanes", 1'b0);
        set_reads();
        run_req('1, "R10 no write by invalid", 1'b0);

        // R2: request offered while busy is ignored
        set_reads();
        for (int l = 0; l < NL; l++) t_addr[l] = 12'(64 + l * 16);
        run_req('1, "R2 ignore while busy", 1'b1);
        for (int l = 0; l < NL; l++) t_addr[l] = 12'(l);
        run_req('1, "R2 no stray write", 1'b0);

        // Mixed pseudo-random patterns over a small address window
        for (int n = 0; n < 300; n++) begin
            logic [NL-1:0] vm;
            seed = nxt(seed);
            vm = seed[15:0];
            seed = nxt(seed);
            t_we = seed[15:0] & seed[31:16];
            for (int l = 0; l < NL; l++) begin
                seed = nxt(seed);
                t_addr[l] = {6'b0, seed[5:0]};
                t_wd[l] = nxt(seed ^ 32'h0F0F_0F0F);
            end
            run_req(vm, "R6 R8 random", 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule